// File: doc/BRIEF.md
# Phase Accumulator Oscillator with Last-Write Shadow

This block is a 32-bit numerically controlled oscillator. On every clock in which it is enabled, it adds a frequency increment to a phase accumulator. It drives one pin of a pin vector from that accumulation. In the oscillator mode the pin follows the top bit of the phase. In the duty mode the pin follows the carry produced by the phase addition, so it gives one-clock pulses whose density is set by the increment.

Software, or a neighbouring sequencer, controls the block through a simple register port. That port can write a value, add to a register or subtract from it. A write to the phase register replaces the accumulation for that clock, and it also loads a shadow copy of the value written. An add or a subtract aimed at the phase register uses that shadow copy as its operand, not the running count. A phase shift can therefore be applied relative to the last value written, whatever the counter has done since. Nothing reloads a register on its own: only port operations change the frequency, and only port operations or accumulation change the phase.

Top module: `nco_shadow_counter`

## Requirements
- R1: Reset clears the control, frequency, phase and shadow registers, and drives every pin low.
- R2: While the mode field is 4 (oscillator) or 6 (duty) and no operation targets the phase register, the phase becomes phase plus frequency, modulo 2^32, at every clock.
- R3: In mode 4, the selected pin equals bit 31 of the live phase.
- R4: In mode 6, the selected pin equals the carry out of the phase addition made at the most recent clock edge. It is high for exactly one clock after each wrap of the phase.
- R5: A write operation (op code 0) to the phase register (address 2) takes priority over that clock's accumulation. After the edge, both the phase and the shadow hold the written value.
- R6: An add (op code 1) or subtract (op code 2) aimed at the phase register computes shadow plus or minus the data. The result goes into both the phase and the shadow. The running count is not used as the operand.
- R7: An add or subtract aimed at the frequency register (address 1) or the control register (address 0) uses that register's live value.
- R8: Any mode code other than 4 or 6, including 0, holds the phase unchanged and drives all pins low.
- R9: In the control register, bits 5:0 select the pin and bits 12:8 hold the mode. All other bits read as zero. No pin other than the selected one is ever high.
- R10: A frequency of all ones makes the phase count down by one per clock.
- R11: No pin or carry event reloads the frequency or the phase. The frequency stays as written, and the phase follows R2 through any number of wraps.
- R12: A read returns the control register at address 0, the frequency at address 1, the live phase at address 2 and zero at address 3. A read has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| busValid | input | 1 | Qualifies an operation in this cycle |
| busOp | input | 2 | 0 write, 1 add, 2 subtract, 3 no operation |
| busAddr | input | 2 | Register select for operation and read |
| busWdata | input | 32 | Operand data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| pinOut | output | 64 | Pin vector; only the selected pin may be driven high |

## Verification
The accumulation is tried with several increment patterns, and each pattern separates a different kind of fault. A small increment shows the per-clock sum and the one-cycle latency from enabling. A quarter-turn increment walks bit 31 through both levels. A half-turn and a 0x6000_0000 increment in the duty mode test carry pulses and wrapping. An all-ones increment must count down. Running phase writes, adds and subtracts are issued at known counts, so a design that takes its operand from the live phase gives a different value from one that takes it from the shadow. A reset between operations shows whether the shadow is cleared.

// File: rtl/nco_shadow_pkg.sv
package nco_shadow_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_ADD   = 2'd1,
    OP_SUB   = 2'd2,
    OP_NONE  = 2'd3
  } busOpE;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_FREQ  = 2'd1,
    REG_PHASE = 2'd2,
    REG_VOID  = 2'd3
  } regSelE;

  localparam logic [4:0] MODE_OFF  = 5'd0;
  localparam logic [4:0] MODE_NCO  = 5'd4;
  localparam logic [4:0] MODE_DUTY = 5'd6;

  // strobes from the port decoder to the datapath
  typedef struct packed {
    logic ctrlLoad;
    logic freqLoad;
    logic phaseLoad;
    logic useAdd;
    logic useSub;
  } strobeT;

endpackage

// File: rtl/nco_bus_decode.sv
module nco_bus_decode
  import nco_shadow_pkg::*;
(
  input  logic       busValid,
  input  logic [1:0] busOp,
  input  logic [1:0] busAddr,
  output strobeT     strobes
);

  logic opLive;

  always_comb begin
    opLive            = busValid && (busOp != OP_NONE);
    strobes           = '0;
    strobes.ctrlLoad  = opLive && (busAddr == REG_CTRL);
    strobes.freqLoad  = opLive && (busAddr == REG_FREQ);
    strobes.phaseLoad = opLive && (busAddr == REG_PHASE);
    strobes.useAdd    = opLive && (busOp == OP_ADD);
    strobes.useSub    = opLive && (busOp == OP_SUB);
  end

endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_shadow_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MODE_W    = 5,
  parameter int PIN_SEL_W = 6,
  parameter int MODE_LSB  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobeT                     strobes,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [1:0]                 rdAddr,
  output logic [DATA_W-1:0]          rdata,
  output logic [DATA_W-1:0]          phaseQ,
  output logic [DATA_W-1:0]          shadowQ,
  output logic [DATA_W-1:0]          freqQ,
  output logic [MODE_W-1:0]          modeQ,
  output logic [(2**PIN_SEL_W)-1:0]  pinOut
);

  localparam int PIN_COUNT = 2 ** PIN_SEL_W;

  // control bits that hold state; all others read zero
  localparam logic [DATA_W-1:0] CTRL_MASK =
    ((DATA_W'(1) << PIN_SEL_W) - DATA_W'(1)) |
    (((DATA_W'(1) << MODE_W) - DATA_W'(1)) << MODE_LSB);

  logic [DATA_W-1:0]    ctrlQ;
  logic [PIN_SEL_W-1:0] pinSelQ;
  logic                 carryQ;
  logic [DATA_W-1:0]    phaseNew, freqNew, ctrlNew;
  logic [DATA_W-1:0]    sum;
  logic                 sumCarry;
  logic                 runEn;
  logic                 level;

  function automatic logic [DATA_W-1:0] applyOp(
    input logic [DATA_W-1:0] base,
    input logic [DATA_W-1:0] data,
    input logic              addSel,
    input logic              subSel
  );
    if (addSel)      return base + data;
    else if (subSel) return base - data;
    else             return data;
  endfunction

  always_comb begin
    modeQ    = ctrlQ[MODE_LSB +: MODE_W];
    pinSelQ  = ctrlQ[PIN_SEL_W-1:0];
    runEn    = (modeQ == MODE_NCO) || (modeQ == MODE_DUTY);
    {sumCarry, sum} = {1'b0, phaseQ} + {1'b0, freqQ};
    // phase read-modify-write draws on the last-written value
    phaseNew = applyOp(shadowQ, wdata, strobes.useAdd, strobes.useSub);
    freqNew  = applyOp(freqQ,   wdata, strobes.useAdd, strobes.useSub);
    ctrlNew  = applyOp(ctrlQ,   wdata, strobes.useAdd, strobes.useSub) & CTRL_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ  <= '0;
      shadowQ <= '0;
      carryQ  <= 1'b0;
    end else if (strobes.phaseLoad) begin
      phaseQ  <= phaseNew;
      shadowQ <= phaseNew;
      carryQ  <= 1'b0;
    end else if (runEn) begin
      phaseQ  <= sum;
      carryQ  <= sumCarry;
    end else begin
      carryQ  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freqQ <= '0;
      ctrlQ <= '0;
    end else begin
      if (strobes.freqLoad) freqQ <= freqNew;
      if (strobes.ctrlLoad) ctrlQ <= ctrlNew;
    end
  end

  always_comb begin
    unique case (rdAddr)
      REG_CTRL:  rdata = ctrlQ;
      REG_FREQ:  rdata = freqQ;
      REG_PHASE: rdata = phaseQ;
      default:   rdata = '0;
    endcase
  end

  always_comb begin
    if (modeQ == MODE_DUTY)     level = carryQ;
    else if (modeQ == MODE_NCO) level = phaseQ[DATA_W-1];
    else                        level = 1'b0;
  end

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    assign pinOut[i] = level && (pinSelQ == PIN_SEL_W'(i));
  end

endmodule

// File: rtl/nco_shadow_counter.sv
module nco_shadow_counter
  import nco_shadow_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MODE_W    = 5,
  parameter int PIN_SEL_W = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      busValid,
  input  logic [1:0]                busOp,
  input  logic [1:0]                busAddr,
  input  logic [DATA_W-1:0]         busWdata,
  output logic [DATA_W-1:0]         busRdata,
  output logic [(2**PIN_SEL_W)-1:0] pinOut
);

  strobeT            strobes;
  logic [DATA_W-1:0] phaseQ;
  logic [DATA_W-1:0] shadowQ;
  logic [DATA_W-1:0] freqQ;
  logic [MODE_W-1:0] modeQ;

  nco_bus_decode u_decode (
    .busValid (busValid),
    .busOp    (busOp),
    .busAddr  (busAddr),
    .strobes  (strobes)
  );

  nco_datapath #(
    .DATA_W    (DATA_W),
    .MODE_W    (MODE_W),
    .PIN_SEL_W (PIN_SEL_W)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wdata   (busWdata),
    .rdAddr  (busAddr),
    .rdata   (busRdata),
    .phaseQ  (phaseQ),
    .shadowQ (shadowQ),
    .freqQ   (freqQ),
    .modeQ   (modeQ),
    .pinOut  (pinOut)
  );

endmodule

// File: rtl/nco_shadow_checker.sv
module nco_shadow_checker
  import nco_shadow_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        busValid,
  input logic [1:0]  busOp,
  input logic [1:0]  busAddr,
  input logic [31:0] busWdata,
  input logic [63:0] pinOut,
  input logic [31:0] phaseQ,
  input logic [31:0] shadowQ,
  input logic [31:0] freqQ,
  input logic [4:0]  modeQ
);

  logic phaseOp;
  logic running;
  assign phaseOp = busValid && (busAddr == REG_PHASE) && (busOp != OP_NONE);
  assign running = (modeQ == MODE_NCO) || (modeQ == MODE_DUTY);

  a_r2_accumulate: assert property (@(posedge clk) disable iff (!rstN)
    (!phaseOp && running) |=> (phaseQ == $past(phaseQ) + $past(freqQ)));

  a_r5_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (phaseOp && busOp == OP_WRITE) |=>
      (phaseQ == $past(busWdata) && shadowQ == $past(busWdata)));

  a_r6_add_from_shadow: assert property (@(posedge clk) disable iff (!rstN)
    (phaseOp && busOp == OP_ADD) |=> (phaseQ == $past(shadowQ) + $past(busWdata)));

  a_r6_sub_from_shadow: assert property (@(posedge clk) disable iff (!rstN)
    (phaseOp && busOp == OP_SUB) |=> (phaseQ == $past(shadowQ) - $past(busWdata)));

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!phaseOp && !running) |=> $stable(phaseQ));

  a_r8_pins_low_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!running) |-> (pinOut == '0));

  a_r9_single_pin: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pinOut));

endmodule

bind nco_shadow_counter nco_shadow_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busValid (busValid),
  .busOp    (busOp),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .pinOut   (pinOut),
  .phaseQ   (phaseQ),
  .shadowQ  (shadowQ),
  .freqQ    (freqQ),
  .modeQ    (modeQ)
);

// File: tb/nco_shadow_counter_tb.sv
module nco_shadow_counter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic [1:0]  busOp = 2'd3;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [63:0] pinOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [1:0] A_CTRL = 2'd0, A_FREQ = 2'd1, A_PHASE = 2'd2, A_VOID = 2'd3;
  localparam logic [1:0] O_WR = 2'd0, O_ADD = 2'd1, O_SUB = 2'd2;
  localparam logic [31:0] C_OFF = 32'h0;

  always #4 clk = ~clk;

  nco_shadow_counter u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busOp(busOp),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .pinOut(pinOut)
  );

  function automatic logic [31:0] ctrlWord(input int mode, input int pin);
    return (32'(mode) << 8) | 32'(pin);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called just after a falling edge; the operation lands on the next rising edge
  task automatic busOpDo(input logic [1:0] addr, input logic [1:0] op, input logic [31:0] data);
    busValid = 1'b1; busAddr = addr; busOp = op; busWdata = data;
    @(negedge clk);
    busValid = 1'b0; busOp = 2'd3;
  endtask

  task automatic rd(input logic [1:0] addr, output logic [31:0] val);
    busAddr = addr;
    #1;
    val = busRdata;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    doReset();
    rd(A_CTRL, v);  check("R1 ctrl after reset", 64'(v), 64'h0);
    rd(A_FREQ, v);  check("R1 freq after reset", 64'(v), 64'h0);
    rd(A_PHASE, v); check("R1 phase after reset", 64'(v), 64'h0);
    check("R1 pins after reset", pinOut, 64'h0);
    rd(A_VOID, v);  check("R12 unused address reads zero", 64'(v), 64'h0);
  endtask

  task automatic t_accumulate();
    logic [31:0] v;
    doReset();
    busOpDo(A_FREQ, O_WR, 32'h1000);
    busOpDo(A_PHASE, O_WR, 32'h10);
    repeat (3) @(negedge clk);
    rd(A_PHASE, v); check("R8 mode 0 holds phase", 64'(v), 64'h10);
    busOpDo(A_CTRL, O_WR, ctrlWord(4, 5));
    repeat (5) @(negedge clk);
    rd(A_PHASE, v); check("R2 five accumulations", 64'(v), 64'h5010);
    rd(A_PHASE, v); check("R12 read has no side effect", 64'(v), 64'h5010);
  endtask

  task automatic t_ncoPin();
    doReset();
    busOpDo(A_FREQ, O_WR, 32'h4000_0000);
    busOpDo(A_CTRL, O_WR, ctrlWord(4, 3));
    @(negedge clk); #1;
    check("R3 phase 0x4000_0000 pin low", pinOut, 64'h0);
    @(negedge clk); #1;
    check("R3 phase 0x8000_0000 pin 3 high", pinOut, 64'h8);
    @(negedge clk); #1;
    check("R3 phase 0xC000_0000 pin 3 high", pinOut, 64'h8);
    @(negedge clk); #1;
    check("R3 phase wraps pin low", pinOut, 64'h0);
  endtask

  task automatic t_dutyPin();
    logic [31:0] v;
    doReset();
    busOpDo(A_FREQ, O_WR, 32'h8000_0000);
    busOpDo(A_CTRL, O_WR, ctrlWord(6, 7));
    @(negedge clk); #1;
    check("R4 no carry yet though bit31 set", pinOut, 64'h0);
    @(negedge clk); #1;
    check("R4 carry pulse on pin 7", pinOut, 64'h80);
    @(negedge clk); #1;
    check("R4 pulse lasts one clock", pinOut, 64'h0);
    doReset();
    busOpDo(A_FREQ, O_WR, 32'h6000_0000);
    busOpDo(A_CTRL, O_WR, ctrlWord(6, 2));
    repeat (7) @(negedge clk);
    rd(A_PHASE, v); check("R11 phase follows sum through wraps", 64'(v), 64'hA000_0000);
    rd(A_FREQ, v);  check("R11 freq not reloaded", 64'(v), 64'h6000_0000);
  endtask

  task automatic t_writePriority();
    logic [31:0] v;
    doReset();
    busOpDo(A_FREQ, O_WR, 32'h1);
    busOpDo(A_CTRL, O_WR, ctrlWord(4, 0));
    repeat (3) @(negedge clk);
    rd(A_PHASE, v); check("R2 count three", 64'(v), 64'h3);
    busOpDo(A_PHASE, O_WR, 32'h100);
    rd(A_PHASE, v); check("R5 write beats accumulation", 64'(v), 64'h100);
    @(negedge clk);
    rd(A_PHASE, v); check("R5 accumulation resumes", 64'(v), 64'h101);
  endtask

  task automatic t_shadowRmw();
    logic [31:0] v;
    doReset();
    busOpDo(A_FREQ, O_WR, 32'h10);
    busOpDo(A_PHASE, O_WR, 32'h1000);
    busOpDo(A_CTRL, O_WR, ctrlWord(4, 1));
    repeat (4) @(negedge clk);
    rd(A_PHASE, v); check("R2 live phase before add", 64'(v), 64'h1040);
    busOpDo(A_PHASE, O_ADD, 32'h5);
    rd(A_PHASE, v); check("R6 add uses shadow", 64'(v), 64'h1005);
    @(negedge clk);
    busOpDo(A_PHASE, O_SUB, 32'h3);
    rd(A_PHASE, v); check("R6 subtract uses updated shadow", 64'(v), 64'h1002);
    @(negedge clk);
    rd(A_PHASE, v); check("R6 accumulates after rmw", 64'(v), 64'h1012);
  endtask

  task automatic t_liveRmw();
    logic [31:0] v;
    doReset();
    busOpDo(A_FREQ, O_WR, 32'h10);
    busOpDo(A_FREQ, O_ADD, 32'h20);
    rd(A_FREQ, v); check("R7 freq add on live value", 64'(v), 64'h30);
    busOpDo(A_FREQ, O_SUB, 32'h8);
    rd(A_FREQ, v); check("R7 freq subtract on live value", 64'(v), 64'h28);
    busOpDo(A_CTRL, O_WR, 32'hFFFF_FFFF);
    rd(A_CTRL, v); check("R9 ctrl field mask", 64'(v), 64'h1F3F);
    check("R8 mode 31 pins low", pinOut, 64'h0);
    busOpDo(A_CTRL, O_WR, ctrlWord(4, 3));
    busOpDo(A_CTRL, O_ADD, 32'h1);
    rd(A_CTRL, v); check("R7 ctrl add on live value", 64'(v), 64'h0404);
  endtask

  task automatic t_countDownAndStop();
    logic [31:0] v, p1;
    doReset();
    busOpDo(A_FREQ, O_WR, 32'hFFFF_FFFF);
    busOpDo(A_PHASE, O_WR, 32'd10);
    busOpDo(A_CTRL, O_WR, ctrlWord(4, 0));
    repeat (3) @(negedge clk);
    rd(A_PHASE, v); check("R10 counts down to 7", 64'(v), 64'd7);
    check("R10 pin low while positive", pinOut, 64'h0);
    repeat (8) @(negedge clk);
    rd(A_PHASE, v); check("R10 reaches all ones", 64'(v), 64'hFFFF_FFFF);
    check("R9 only pin 0 high", pinOut, 64'h1);
    busOpDo(A_CTRL, O_WR, C_OFF);
    rd(A_PHASE, p1);
    check("R8 pins low in mode 0", pinOut, 64'h0);
    repeat (5) @(negedge clk);
    rd(A_PHASE, v); check("R8 phase frozen in mode 0", 64'(v), 64'(p1));
  endtask

  task automatic t_resetShadow();
    logic [31:0] v;
    doReset();
    busOpDo(A_PHASE, O_WR, 32'h55);
    doReset();
    busOpDo(A_PHASE, O_ADD, 32'h1);
    rd(A_PHASE, v); check("R1 shadow cleared by reset", 64'(v), 64'h1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_accumulate();
    t_ncoPin();
    t_dutyPin();
    t_writePriority();
    t_shadowRmw();
    t_liveRmw();
    t_countDownAndStop();
    t_resetShadow();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule